// File: doc/BRIEF.md
# Adaptive Sequential Prefetch Controller

This block sits next to a data cache and issues prefetches of the block addresses that follow a missing block. On a read miss to block B it offers B+1, B+2 and so on up to B+K on a valid/ready request port, one per cycle, where K is the current lookahead degree. A new miss drops whatever part of the previous run has not yet been issued. A candidate is skipped when the cache flags it as already resident. The run stops at the first candidate above the configured highest block address.

K adapts at run time. Every line filled by a prefetch gets a per-line prefetch flag, which is written through the block's flag-update port. A demand hit that sees the flag set counts as a useful prefetch and clears the flag. Returned prefetches and useful hits are counted. Each time sixteen prefetches have returned, the useful count is compared against two thresholds, K moves up or down by one within 0 to MAX_DEG, and both counters restart.

While K is 0, each miss tags the block that would have been prefetched with a per-line zero flag. Demand hits on zero-flagged lines feed a probe counter, and enough of them bring K back to 1. A hold input freezes K, which gives a fixed-degree configuration.

Top module: `adaptive_prefetcher`

## Requirements
- R1: After reset, degree is 1, pf_valid is low and flag_valid is low.
- R2: After a miss to block B with degree K>0, the requests B+1 through B+K appear on pf_addr in increasing order starting the next cycle. The port advances only when pf_valid and pf_ready are both high, and pf_addr holds while a request waits.
- R3: A miss arriving while a run is in progress restarts the run from the new address and discards the rest of the old run.
- R4: A candidate is skipped without being offered in a cycle where pf_resident is high. A candidate above ADDR_LIMIT ends the run, and no address above ADDR_LIMIT is ever offered.
- R5: The flag port writes at most one command per cycle, in this priority order. A hit with the prefetch flag clears it (flag_sel=0, flag_val=0). A hit with only the zero flag clears that flag (flag_sel=1, flag_val=0). A prefetch return sets the prefetch flag at ret_addr (flag_sel=0, flag_val=1). A miss taken while degree is 0 sets the zero flag at B+1 (flag_sel=1, flag_val=1). A lower-priority command in the same cycle is dropped.
- R6: A miss taken while degree is 0 issues no request. It marks B+1 with the zero flag if B+1 does not exceed ADDR_LIMIT.
- R7: In the cycle the sixteenth return of a window arrives, degree rises by one if at least 12 useful hits were counted in the window (including that cycle). Both counters then restart at zero.
- R8: At window end, degree falls by one if fewer than 6 useful hits were counted and is otherwise unchanged. It stays within 0 to MAX_DEG (default 8).
- R9: While degree is 0, the fourth zero-flag hit sets degree to 1.
- R10: While hold_degree is high, degree does not change, although windows and probe counts still restart.
- R11: Degree never changes by more than one between consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Read miss event |
| miss_addr | input | AW | Block address of the miss |
| hit_valid | input | 1 | Demand hit event |
| hit_addr | input | AW | Block address of the hit line |
| hit_pf_bit | input | 1 | Prefetch flag of the hit line |
| hit_zero_bit | input | 1 | Zero flag of the hit line |
| ret_valid | input | 1 | A prefetched block returned |
| ret_addr | input | AW | Block address of the returned block |
| hold_degree | input | 1 | Freeze the lookahead degree |
| pf_valid | output | 1 | Prefetch request valid |
| pf_ready | input | 1 | Request accepted by memory side |
| pf_addr | output | AW | Prefetch request block address |
| pf_resident | input | 1 | Cache reports pf_addr already resident |
| flag_valid | output | 1 | Flag update command valid |
| flag_addr | output | AW | Line address to update |
| flag_sel | output | 1 | 0 = prefetch flag, 1 = zero flag |
| flag_val | output | 1 | Value to write into the selected flag |
| degree | output | KW | Current lookahead degree |

## Verification
The assertions check four things on every cycle: degree stays in range and moves by at most one step, a stalled request keeps its address, no request exceeds the address limit, and flag commands only appear alongside an event. Whether the degree moves in the correct direction at a window boundary, whether the probe restores it, and whether requests come in the right order all depend on history across many cycles. Only the bench's scenarios can show those, with a reference model checked against the ports on every clock.

// File: rtl/adaptive_prefetcher.sv
module adaptive_prefetcher #(
  parameter int AW = 16,
  parameter int MAX_DEG = 8,
  parameter int WINDOW = 16,
  parameter int UP_TH = 12,
  parameter int DOWN_TH = 6,
  parameter int PROBE_HITS = 4,
  parameter logic [AW-1:0] ADDR_LIMIT = '1,
  localparam int KW = $clog2(MAX_DEG + 1),
  localparam int CW = $clog2(WINDOW + 1),
  localparam int ZW = $clog2(PROBE_HITS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          miss_valid,
  input  logic [AW-1:0] miss_addr,
  input  logic          hit_valid,
  input  logic [AW-1:0] hit_addr,
  input  logic          hit_pf_bit,
  input  logic          hit_zero_bit,
  input  logic          ret_valid,
  input  logic [AW-1:0] ret_addr,
  input  logic          hold_degree,
  output logic          pf_valid,
  input  logic          pf_ready,
  output logic [AW-1:0] pf_addr,
  input  logic          pf_resident,
  output logic          flag_valid,
  output logic [AW-1:0] flag_addr,
  output logic          flag_sel,
  output logic          flag_val,
  output logic [KW-1:0] degree
);
  logic [KW-1:0] k_q, k_nx, idx, last;
  logic [CW-1:0] pcnt, ucnt, pcnt_n, ucnt_n;
  logic [ZW-1:0] zcnt, zcnt_nx;
  logic [AW-1:0] base;
  logic          busy;

  wire [AW:0] cand = {1'b0, base} + (AW+1)'(idx);
  wire        over = cand > {1'b0, ADDR_LIMIT};
  wire [AW:0] mark = {1'b0, miss_addr} + (AW+1)'(1);
  wire        k_zero = (k_q == '0);
  wire        useful = hit_valid & hit_pf_bit;
  wire        zhit = hit_valid & ~hit_pf_bit & hit_zero_bit;
  wire        mark_ok = miss_valid & k_zero & (mark <= {1'b0, ADDR_LIMIT});

  assign pf_addr  = cand[AW-1:0];
  assign pf_valid = busy & ~over & ~pf_resident;
  assign degree   = k_q;

  always_comb begin
    flag_valid = 1'b1;
    flag_addr  = hit_addr;
    flag_sel   = 1'b0;
    flag_val   = 1'b0;
    if (useful) begin
      flag_sel = 1'b0;
    end else if (zhit) begin
      flag_sel = 1'b1;
    end else if (ret_valid) begin
      flag_addr = ret_addr;
      flag_val  = 1'b1;
    end else if (mark_ok) begin
      flag_addr = mark[AW-1:0];
      flag_sel  = 1'b1;
      flag_val  = 1'b1;
    end else begin
      flag_valid = 1'b0;
    end
  end

  assign ucnt_n = (useful && ucnt != CW'(WINDOW)) ? ucnt + 1'b1 : ucnt;
  assign pcnt_n = pcnt + CW'(ret_valid);
  wire win_done = (pcnt_n == CW'(WINDOW));

  always_comb begin
    k_nx    = k_q;
    zcnt_nx = zcnt;
    if (win_done && !hold_degree) begin
      if (ucnt_n >= CW'(UP_TH) && k_q != KW'(MAX_DEG)) k_nx = k_q + 1'b1;
      else if (ucnt_n < CW'(DOWN_TH) && !k_zero)       k_nx = k_q - 1'b1;
    end
    if (k_zero) begin
      if (zhit) begin
        if (zcnt + 1'b1 == ZW'(PROBE_HITS)) begin
          zcnt_nx = '0;
          if (!hold_degree) k_nx = KW'(1);
        end else begin
          zcnt_nx = zcnt + 1'b1;
        end
      end
    end else begin
      zcnt_nx = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      k_q  <= KW'(1);
      pcnt <= '0;
      ucnt <= '0;
      zcnt <= '0;
    end else begin
      k_q  <= k_nx;
      zcnt <= zcnt_nx;
      pcnt <= win_done ? '0 : pcnt_n;
      ucnt <= win_done ? '0 : ucnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      base <= '0;
      idx  <= '0;
      last <= '0;
    end else if (miss_valid) begin
      base <= miss_addr;
      idx  <= KW'(1);
      last <= k_q;
      busy <= !k_zero;
    end else if (busy) begin
      if (over) begin
        busy <= 1'b0;
      end else if (pf_resident || pf_ready) begin
        if (idx == last) busy <= 1'b0;
        else idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/adaptive_prefetcher_checker.sv
module adaptive_prefetcher_checker #(
  parameter int AW = 16,
  parameter int MAX_DEG = 8,
  parameter logic [AW-1:0] ADDR_LIMIT = '1,
  localparam int KW = $clog2(MAX_DEG + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          miss_valid,
  input logic          hit_valid,
  input logic          ret_valid,
  input logic          pf_valid,
  input logic          pf_ready,
  input logic [AW-1:0] pf_addr,
  input logic          flag_valid,
  input logic [KW-1:0] degree
);
  a_r8_degree_range: assert property (@(posedge clk) disable iff (!rst_n)
    degree <= KW'(MAX_DEG));

  a_r11_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (degree != $past(degree)) |->
      (degree == $past(degree) + 1'b1 || degree + 1'b1 == $past(degree)));

  a_r2_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !pf_ready && !miss_valid) |=> $stable(pf_addr));

  a_r4_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> pf_addr <= ADDR_LIMIT);

  a_r5_flag_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    flag_valid |-> (hit_valid || ret_valid || miss_valid));
endmodule

bind adaptive_prefetcher adaptive_prefetcher_checker #(
  .AW(AW), .MAX_DEG(MAX_DEG), .ADDR_LIMIT(ADDR_LIMIT)
) u_chk (.*);

// File: tb/tb_adaptive_prefetcher.sv
`timescale 1ns/1ps
module tb_adaptive_prefetcher;
  localparam int AW = 16;
  localparam logic [AW-1:0] LIM = 16'hFF00;
  localparam int KW = 4;

  logic clk = 0, rst_n = 0;
  logic miss_valid = 0, hit_valid = 0, hit_pf_bit = 0, hit_zero_bit = 0;
  logic ret_valid = 0, hold_degree = 0, pf_ready = 0, pf_resident = 0;
  logic [AW-1:0] miss_addr = 0, hit_addr = 0, ret_addr = 0;
  logic pf_valid, flag_valid, flag_sel, flag_val;
  logic [AW-1:0] pf_addr, flag_addr;
  logic [KW-1:0] degree;

  always #4 clk = ~clk;

  adaptive_prefetcher #(.AW(AW), .ADDR_LIMIT(LIM)) dut (.*);

  int errors = 0, checks = 0;
  string ctx = "R1";
  int m_k = 1, m_p = 0, m_u = 0, m_z = 0, m_base = 0, m_idx = 0, m_last = 0;
  bit m_busy = 0;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s/%s: actual=%0h expected=%0h at %0t", ctx, tag, act, exp, $time);
    end
  endtask

  task automatic step();
    int cand, ucn, pcn, kn, zn, fa, fs, fv;
    bit ov, epv, useful, zhit, fvld;
    #1;
    cand = m_base + m_idx;
    ov = cand > LIM;
    epv = m_busy && !ov && !pf_resident;
    useful = hit_valid && hit_pf_bit;
    zhit = hit_valid && !hit_pf_bit && hit_zero_bit;
    fvld = 1; fa = hit_addr; fs = 0; fv = 0;
    if (useful) begin fs = 0; end
    else if (zhit) begin fs = 1; end
    else if (ret_valid) begin fa = ret_addr; fv = 1; end
    else if (miss_valid && m_k == 0 && miss_addr + 1 <= LIM) begin fa = miss_addr + 1; fs = 1; fv = 1; end
    else fvld = 0;
    check("R11 degree", degree, m_k);
    check("R2 pf_valid", pf_valid, epv);
    if (epv) check("R2 pf_addr", pf_addr, cand);
    check("R5 flag_valid", flag_valid, fvld);
    if (fvld) begin
      check("R5 flag_addr", flag_addr, fa);
      check("R5 flag_sel", flag_sel, fs);
      check("R5 flag_val", flag_val, fv);
    end
    ucn = m_u + ((useful && m_u < 16) ? 1 : 0);
    pcn = m_p + (ret_valid ? 1 : 0);
    kn = m_k; zn = m_z;
    if (pcn == 16) begin
      if (!hold_degree) begin
        if (ucn >= 12 && m_k < 8) kn = m_k + 1;
        else if (ucn < 6 && m_k > 0) kn = m_k - 1;
      end
      pcn = 0; ucn = 0;
    end
    if (m_k == 0) begin
      if (zhit) begin
        if (m_z + 1 == 4) begin zn = 0; if (!hold_degree) kn = 1; end
        else zn = m_z + 1;
      end
    end else zn = 0;
    if (miss_valid) begin
      m_base = miss_addr; m_idx = 1; m_last = m_k; m_busy = (m_k > 0);
    end else if (m_busy) begin
      if (ov) m_busy = 0;
      else if (pf_resident || pf_ready) begin
        if (m_idx == m_last) m_busy = 0; else m_idx++;
      end
    end
    m_k = kn; m_p = pcn; m_u = ucn; m_z = zn;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic window(int n_useful);
    for (int i = 0; i < 16; i++) begin
      ret_valid = 1; ret_addr = AW'(16'h0800 + i);
      hit_valid = (i < n_useful); hit_pf_bit = 1; hit_addr = AW'(16'h0900 + i);
      step();
    end
    ret_valid = 0; hit_valid = 0; hit_pf_bit = 0;
  endtask

  task automatic miss(int a);
    miss_valid = 1; miss_addr = AW'(a);
    step();
    miss_valid = 0;
  endtask

  initial begin
    #200000000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    ctx = "R1";
    check("R1 reset degree", degree, 1);
    check("R1 reset pf_valid", pf_valid, 0);
    check("R1 reset flag_valid", flag_valid, 0);
    rst_n = 1;
    idle(2);

    ctx = "R2"; pf_ready = 1;
    miss(16'h0100); idle(3);

    ctx = "R7"; window(12); idle(1);

    ctx = "R2"; pf_ready = 0;
    miss(16'h0180); idle(2); pf_ready = 1; idle(3);

    ctx = "R3"; pf_ready = 0;
    miss(16'h0200); idle(2);
    miss(16'h0300); pf_ready = 1; idle(4);

    ctx = "R4";
    miss(16'h0400); pf_resident = 1; step(); pf_resident = 0; idle(3);
    miss(16'hFEFF); idle(4);

    ctx = "R5";
    ret_valid = 1; ret_addr = 16'h0A00; hit_valid = 1; hit_zero_bit = 1; hit_addr = 16'h0A10;
    step();
    hit_valid = 0; hit_zero_bit = 0; step(); ret_valid = 0; idle(1);

    ctx = "R8";
    for (int i = 0; i < 7; i++) window(16);
    window(8);

    ctx = "R10"; hold_degree = 1;
    window(0); window(16); hold_degree = 0; idle(1);

    ctx = "R8";
    for (int i = 0; i < 9; i++) window(0);

    ctx = "R6";
    miss(16'h0500); idle(2);
    miss(16'hFF00); idle(1);

    ctx = "R9";
    hit_zero_bit = 1; hit_pf_bit = 0; hit_addr = 16'h0501;
    for (int i = 0; i < 3; i++) begin hit_valid = 1; step(); hit_valid = 0; step(); end
    hit_valid = 1; step(); hit_valid = 0; hit_zero_bit = 0;
    idle(2);
    miss(16'h0600); idle(3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule